// File: doc/BRIEF.md
# Serial Configuration Slave for a Clock Fan-Out Buffer

This block is the two-wire configuration port of a clock fan-out buffer. It works as an SMBus slave and holds two 8-bit configuration registers. Their bits drive the per-pair output enables, the two feedback-clock enables and a 2-bit input threshold select. The block samples SCL and SDA with its own system clock and detects START, repeated START and STOP. It compares the 7-bit device address and pulls SDA low through an open-drain enable to acknowledge bytes and to send read data.

Bit 7 of the command byte picks one of two access styles. A single indexed byte transfers one register at the offset carried in bits 6:0. A counted block transfer always starts at offset 0 and carries a byte count in both directions. After reset, every clock output is active, so software never has to touch the port.

Top module: `clkfan_cfg_slave`

## Requirements
- R1: The slave acknowledges (SDA low during the 9th SCL clock) an address byte whose upper seven bits are 1101001, with the R/W bit either 0 (byte 0xD2) or 1 (byte 0xD3).
- R2: An address byte carrying any other 7-bit address is not acknowledged. The slave then leaves SDA undriven and changes no register until the next START.
- R3: A command byte with bit 7 = 1 selects byte access at the offset in bits 6:0. In a write, the first data byte is stored there. Further data bytes are acknowledged and discarded, and every byte of the write is acknowledged.
- R4: After a byte-access command, a repeated START and address 0xD3, the slave sends the register at that offset, MSB first.
- R5: A command byte with bit 7 = 0 selects block access. The next byte is a count N, and the following data bytes are stored at offsets 0, 1, … upward. Only the first N data bytes are stored; later ones are acknowledged and discarded.
- R6: A block read (command 0x00, repeated START, 0xD3) returns the count 0x02, then register 0, then register 1, then 0x00 for as long as the master acknowledges. After the master's NACK, the slave stops driving SDA.
- R7: Offsets 2 and above hold no register. Writes to them are acknowledged and discarded, and reads from them return 0x00.
- R8: After reset, pair_en is all ones, fb_en is 2'b11 and thresh_sel is 2'b00.
- R9: thresh_sel is register 0 bits 7:6. fb_en[0] is the inverse of register 0 bit 5, and fb_en[1] is the inverse of register 0 bit 4. pair_en[3:0] is register 0 bits 3:0, and pair_en[11:4] is register 1.
- R10: The slave begins pulling SDA low only while SCL is low. It releases SDA on the cycle after any START or STOP it detects.
- R11: A STOP that interrupts a byte before its eighth bit leaves all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | Pull SDA low when 1 |
| thresh_sel | output | 2 | Input threshold select |
| fb_en | output | 2 | Feedback clock enables, bit 0 = A, bit 1 = B |
| pair_en | output | 12 | Differential clock pair enables |

## Verification
A wrong state in the byte engine shows up on SDA within one byte time. It appears as a missing or extra acknowledge on the 9th clock, or as a shifted or misordered read byte. A wrong pointer or count shows up as a wrong value when the registers are read back, and on the enable outputs as soon as the byte is written. A sync or edge fault shows up on the next SCL high phase as SDA moving while SCL is high, or as SDA staying driven after a START or STOP.

// File: rtl/clkfan_cfg_pkg.sv
package clkfan_cfg_pkg;

    localparam int          CFG_NREG     = 2;
    localparam logic [6:0]  CFG_DEV_ADDR = 7'h69;
    localparam logic [7:0]  CFG_BLK_CNT  = 8'(CFG_NREG);
    localparam int          PAIR_W       = 4 + 8 * (CFG_NREG - 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_SACK,
        S_TX,
        S_MACK
    } bus_state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_CMD,
        K_CNT,
        K_DATA
    } rx_kind_e;

    // layout of register 0 as the output decode sees it
    typedef struct packed {
        logic [1:0] thresh;
        logic       fb_a_off;
        logic       fb_b_off;
        logic [3:0] pair_lo;
    } ctl0_t;

    function automatic logic [7:0] cfg_default(input int idx);
        return (idx == 0) ? 8'h0F : 8'hFF;
    endfunction

    function automatic logic [6:0] ptr_step(input logic [6:0] p);
        return (p == 7'h7F) ? p : p + 7'd1;
    endfunction

endpackage

// File: rtl/clkfan_cfg_sync.sv
module clkfan_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_raw;
                    sda_ff <= sda_raw;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_raw};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_raw};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_ff[STAGES-1];
            sda_p <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/clkfan_cfg_regs.sv
module clkfan_cfg_regs
    import clkfan_cfg_pkg::*;
#(
    parameter int NREG = CFG_NREG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [6:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [6:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic [8*NREG-1:0] flat
);
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

    logic [7:0] bank [NREG];

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    bank[i] <= cfg_default(i);
                else if (we && int'(wr_addr) == i)
                    bank[i] <= wr_data;
            end
            assign flat[8*i +: 8] = bank[i];
        end
    endgenerate

    always_comb begin
        if (int'(rd_addr) < NREG)
            rd_data = bank[rd_addr[IW-1:0]];
        else
            rd_data = 8'h00;
    end
endmodule

// File: rtl/clkfan_cfg_engine.sv
module clkfan_cfg_engine
    import clkfan_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = CFG_DEV_ADDR
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic [7:0] rd_data,
    output logic [6:0] rd_addr,
    output logic       we,
    output logic [6:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    bus_state_e st;
    rx_kind_e   kind;
    logic [7:0] shreg;
    logic [3:0] bitcnt;
    logic       blk;
    logic [6:0] ptr;
    logic [7:0] left;
    logic       cnt_pending;
    logic       go_tx;
    logic       mack_ok;
    logic [7:0] tx_next;

    assign rd_addr = ptr;
    assign tx_next = cnt_pending ? CFG_BLK_CNT : rd_data;

    always_ff @(posedge clk) begin
        we <= 1'b0;
        if (rst) begin
            st          <= S_IDLE;
            kind        <= K_ADDR;
            shreg       <= '0;
            bitcnt      <= '0;
            blk         <= 1'b0;
            ptr         <= '0;
            left        <= '0;
            cnt_pending <= 1'b0;
            go_tx       <= 1'b0;
            mack_ok     <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
            sda_oe      <= 1'b0;
        end else if (start_evt) begin
            st     <= S_RX;
            kind   <= K_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (stop_evt) begin
            st     <= S_IDLE;
            sda_oe <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: ;
                S_RX: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        go_tx  <= 1'b0;
                        st     <= S_SACK;
                        sda_oe <= 1'b1;
                        unique case (kind)
                            K_ADDR: begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    go_tx       <= shreg[0];
                                    cnt_pending <= shreg[0] & blk;
                                    kind        <= K_CMD;
                                end else begin
                                    st     <= S_IDLE;
                                    sda_oe <= 1'b0;
                                end
                            end
                            K_CMD: begin
                                blk  <= ~shreg[7];
                                ptr  <= shreg[7] ? shreg[6:0] : 7'd0;
                                left <= 8'd1;
                                kind <= shreg[7] ? K_DATA : K_CNT;
                            end
                            K_CNT: begin
                                left <= shreg;
                                kind <= K_DATA;
                            end
                            K_DATA: begin
                                if (left != 8'd0) begin
                                    we      <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= shreg;
                                    left    <= left - 8'd1;
                                    ptr     <= ptr_step(ptr);
                                end
                            end
                        endcase
                    end
                end
                S_SACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (go_tx) begin
                            st     <= S_TX;
                            shreg  <= tx_next;
                            sda_oe <= ~tx_next[7];
                            if (cnt_pending) cnt_pending <= 1'b0;
                            else             ptr <= ptr_step(ptr);
                        end else begin
                            st     <= S_RX;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            st     <= S_MACK;
                            sda_oe <= 1'b0;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        mack_ok <= ~sda_s;
                    end else if (scl_fall) begin
                        bitcnt <= '0;
                        if (mack_ok) begin
                            st     <= S_TX;
                            shreg  <= tx_next;
                            sda_oe <= ~tx_next[7];
                            if (cnt_pending) cnt_pending <= 1'b0;
                            else             ptr <= ptr_step(ptr);
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/clkfan_cfg_slave.sv
module clkfan_cfg_slave
    import clkfan_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = CFG_DEV_ADDR,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [1:0]        thresh_sel,
    output logic [1:0]        fb_en,
    output logic [PAIR_W-1:0] pair_en
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic [7:0]        rd_data, wr_data;
    logic [6:0]        rd_addr, wr_addr;
    logic              we;
    logic [8*CFG_NREG-1:0] regs_flat;
    ctl0_t             c0;

    clkfan_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_raw(scl_i), .sda_raw(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    clkfan_cfg_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt), .rd_data(rd_data), .rd_addr(rd_addr),
        .we(we), .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
    );

    clkfan_cfg_regs #(.NREG(CFG_NREG)) u_regs (
        .clk(clk), .rst(rst), .we(we), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .flat(regs_flat)
    );

    assign c0         = ctl0_t'(regs_flat[7:0]);
    assign thresh_sel = c0.thresh;
    assign fb_en      = {~c0.fb_b_off, ~c0.fb_a_off};
    assign pair_en    = {regs_flat[8*CFG_NREG-1:8], c0.pair_lo};
endmodule

// File: rtl/clkfan_cfg_chk.sv
module clkfan_cfg_chk
    import clkfan_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_s,
    input logic              start_evt,
    input logic              stop_evt,
    input logic              sda_oe,
    input logic [1:0]        thresh_sel,
    input logic [1:0]        fb_en,
    input logic [PAIR_W-1:0] pair_en
);
    // R8: the cycle after reset releases, all outputs are active
    p_defaults_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pair_en == '1 && fb_en == 2'b11 && thresh_sel == 2'b00));

    // R10: the slave starts pulling SDA only while SCL is low
    p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    // R10: START or STOP releases SDA on the next cycle
    p_release_bus_r10: assert property (@(posedge clk) disable iff (rst)
        (start_evt || stop_evt) |=> !sda_oe);

    // R10: a release happens with SCL low or right after a bus condition
    p_drop_ok_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> (!scl_s || $past(start_evt || stop_evt)));

    // R11: configuration outputs change only on complete bytes, never while SCL is high
    p_cfg_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable({pair_en, fb_en, thresh_sel}) |-> !scl_s);
endmodule

bind clkfan_cfg_slave clkfan_cfg_chk u_chk (
    .clk(clk), .rst(rst), .scl_s(scl_s), .start_evt(start_evt), .stop_evt(stop_evt),
    .sda_oe(sda_oe), .thresh_sel(thresh_sel), .fb_en(fb_en), .pair_en(pair_en)
);

// File: tb/clkfan_cfg_slave_tb.sv
module clkfan_cfg_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 4;
    localparam int WD_CYCLES  = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [1:0]  thresh_sel;
    logic [1:0]  fb_en;
    logic [11:0] pair_en;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int oe_cycles = 0;
    logic [7:0] e0 = 8'h0F;
    logic [7:0] e1 = 8'hFF;

    assign sda_line = sda_m & ~sda_oe;

    clkfan_cfg_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .thresh_sel(thresh_sel), .fb_en(fb_en), .pair_en(pair_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) oe_cycles <= oe_cycles + int'(sda_oe);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
        end
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = !sda_line; q(); scl_m = 1'b0; q();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; q(); scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0; q();
        end
        sda_m = !ack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q(); sda_m = 1'b1;
    endtask

    // expected outputs computed from the register model (R9)
    task automatic chk_outputs(input string req);
        logic [11:0] xp;
        logic [1:0]  xf;
        xp = {e1, e0[3:0]};
        xf = {~e0[4], ~e0[5]};
        chk(pair_en == xp, req, 32'(pair_en), 32'(xp));
        chk(fb_en == xf, req, 32'(fb_en), 32'(xf));
        chk(thresh_sel == e0[7:6], req, 32'(thresh_sel), 32'(e0[7:6]));
    endtask

    task automatic byte_write(input logic [6:0] off, input logic [7:0] v, output bit all_ack);
        bit a1, a2, a3;
        bus_start(); send_byte(8'hD2, a1); send_byte({1'b1, off}, a2); send_byte(v, a3); bus_stop();
        all_ack = a1 & a2 & a3;
        if (off == 7'd0) e0 = v;
        else if (off == 7'd1) e1 = v;
    endtask

    task automatic byte_read(input logic [6:0] off, output logic [7:0] v, output bit all_ack);
        bit a1, a2, a3;
        bus_start(); send_byte(8'hD2, a1); send_byte({1'b1, off}, a2);
        bus_start(); send_byte(8'hD3, a3); recv_byte(v, 1'b0); bus_stop();
        all_ack = a1 & a2 & a3;
    endtask

    function automatic logic [7:0] model_rd(input int off);
        return (off == 0) ? e0 : (off == 1) ? e1 : 8'h00;
    endfunction

    initial begin
        bit ack, ok;
        logic [7:0] v, rv;
        int snap;
        logic [7:0] blk [4];

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk(pair_en == 12'hFFF, "R8 pair_en", 32'(pair_en), 32'hFFF);
        chk(fb_en == 2'b11, "R8 fb_en", 32'(fb_en), 32'h3);
        chk(thresh_sel == 2'b00, "R8 thresh_sel", 32'(thresh_sel), 32'h0);

        // R2: every foreign address is ignored
        for (int a = 0; a < 128; a++) begin
            bit a1, a2;
            if (a == 'h69) continue;
            snap = oe_cycles;
            bus_start(); send_byte({7'(a), 1'b0}, a1); send_byte(8'h80, a2); send_byte(8'h00, a2); bus_stop();
            chk(!a1 && oe_cycles == snap, "R2 foreign address", 32'(a), 32'h69);
        end
        chk_outputs("R2 no change");

        // R1: matching address acknowledged in both directions
        bus_start(); send_byte(8'hD2, ack); bus_stop();
        chk(ack, "R1 ack write address", 32'(ack), 32'h1);
        bus_start(); send_byte(8'hD3, ack); recv_byte(rv, 1'b0); bus_stop();
        chk(ack, "R1 ack read address", 32'(ack), 32'h1);

        // R3 R4 R9: byte write/read sweep over both registers
        for (int k = 0; k < 18; k++) begin
            v = (k == 16) ? 8'h00 : (k == 17) ? 8'hFF : 8'(k * 37 + 11);
            for (int r = 0; r < 2; r++) begin
                byte_write(7'(r), v ^ 8'(r * 8'h5A), ok);
                chk(ok, "R3 byte write acked", 32'(ok), 32'h1);
                chk_outputs("R9 output mapping");
                byte_read(7'(r), rv, ok);
                chk(ok && rv == model_rd(r), "R4 byte read", 32'(rv), 32'(model_rd(r)));
            end
        end

        // R3: extra byte after a byte write is discarded
        begin
            bit a1, a2, a3, a4;
            bus_start(); send_byte(8'hD2, a1); send_byte(8'h80, a2); send_byte(8'h3C, a3); send_byte(8'h11, a4); bus_stop();
            e0 = 8'h3C;
            chk(a4, "R3 extra byte acked", 32'(a4), 32'h1);
            chk_outputs("R3 extra byte ignored");
        end

        // R7: offsets beyond the bank
        for (int o = 2; o < 10; o++) begin
            byte_write(7'(o), 8'hA5, ok);
            chk(ok, "R7 high offset write acked", 32'(ok), 32'h1);
            chk_outputs("R7 high offset write discarded");
            byte_read(7'(o), rv, ok);
            chk(rv == 8'h00, "R7 high offset read", 32'(rv), 32'h0);
        end
        byte_read(7'h7F, rv, ok);
        chk(rv == 8'h00, "R7 offset 127 read", 32'(rv), 32'h0);

        // R5: block writes with various counts
        for (int n = 0; n < 4; n++) begin
            bit a1;
            bit allack;
            allack = 1'b1;
            blk[0] = 8'(8'h21 + n * 16); blk[1] = 8'(8'hC3 - n * 16); blk[2] = 8'h77; blk[3] = 8'h99;
            bus_start(); send_byte(8'hD2, a1); allack &= a1; send_byte(8'h00, a1); allack &= a1;
            send_byte(8'(n), a1); allack &= a1;
            for (int i = 0; i < 3; i++) begin
                send_byte(blk[i], a1); allack &= a1;
            end
            bus_stop();
            if (n >= 1) e0 = blk[0];
            if (n >= 2) e1 = blk[1];
            chk(allack, "R5 block write acked", 32'(allack), 32'h1);
            chk_outputs("R5 block write count");
        end

        // R6: block read ordering and release after NACK
        bus_start(); send_byte(8'hD2, ack); send_byte(8'h00, ack);
        bus_start(); send_byte(8'hD3, ack);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] xv;
            recv_byte(rv, i < 3);
            xv = (i == 0) ? 8'h02 : model_rd(i - 1);
            chk(rv == xv, "R6 block read byte", 32'(rv), 32'(xv));
        end
        q();
        chk(sda_oe == 1'b0, "R6 released after NACK", 32'(sda_oe), 32'h0);
        bus_stop();
        q();
        chk(sda_oe == 1'b0, "R10 idle after STOP", 32'(sda_oe), 32'h0);

        // R11: STOP inside a data byte leaves registers intact
        bus_start(); send_byte(8'hD2, ack); send_byte(8'h81, ack);
        for (int i = 0; i < 5; i++) begin
            sda_m = 1'b0; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
        end
        bus_stop();
        chk_outputs("R11 cut byte");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule